// File: doc/BRIEF.md
# Unconditional Branch Next-PC Unit

This block keeps the program counter and the link register of a 64-bit RISC core whose instruction bits are numbered big-endian. Each clock it may take one 32-bit instruction word, marked by a valid strobe, and it computes the address of the next instruction from that word and the current PC. One instruction form is decoded: the unconditional displacement jump. The jump has four flavours. Its target is either relative to the current instruction or an absolute address, and in either case it may also save a return address.

A word that is valid but is not this jump moves the PC forward by one instruction. The unit holds its state while the strobe is low. The core reads the PC and the link register straight from the outputs. Two single-cycle pulses report a redirect and a link write, and each pulse comes in the same cycle as the new register value. A reset-vector input gives the first PC.

Top module: `ubr_nextpc`

## Requirements
- R1: A clock edge with `rst` high loads `pc` from `reset_vec`, clears `lr` to zero and drives `taken` and `link_we` low.
- R2: A valid word is the jump when its top six bits `insn[31:26]` (big-endian bits 0–5) equal 18. The signed word offset is `insn[25:2]`, the absolute flag is `insn[1]` and the link flag is `insn[0]`.
- R3: With the absolute flag at 0, the next `pc` is the current `pc` plus the offset shifted left by two and sign-extended to 64 bits.
- R4: With the absolute flag at 1, the next `pc` is the shifted, sign-extended offset itself, and its two low bits are zero.
- R5: With the link flag at 1, `lr` takes the old `pc` plus 4 in the same update that redirects `pc`. With the link flag at 0, `lr` is unchanged.
- R6: A valid word that is not the jump sets `pc` to `pc` plus 4, leaves `lr` unchanged and raises no pulse.
- R7: While `insn_valid` is low, `pc` and `lr` hold and both pulses stay low, whatever `insn` carries.
- R8: `taken` is high for exactly the one cycle in which a jump's target appears on `pc`. `link_we` is high only in the cycle in which `lr` shows a newly written value.
- R9: The offset field reaches from −2^25 (field 0x800000) up to +2^25 − 4 (field 0x7FFFFF) bytes.
- R10: The relative addition wraps modulo 2^64 and has no overflow indication.
- R11: A second linked jump overwrites the return address left by the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_vec | input | 64 | PC value loaded on reset |
| insn_valid | input | 1 | Instruction word is present this cycle |
| insn | input | 32 | Instruction word, bit 31 = big-endian bit 0 |
| pc | output | 64 | Current instruction address |
| lr | output | 64 | Link register |
| taken | output | 1 | Pulse: pc was just redirected by the jump |
| link_we | output | 1 | Pulse: lr was just written |

## Verification
The checker tests these rules on every cycle: state holds while the strobe is low; sequential advance and no pulse for words that are not jumps; absolute targets land on aligned addresses; `link_we` only comes with `taken`; and a written link value is the previous PC plus four. Other behaviour depends on chosen data, so only the bench scenarios show it. This covers the exact relative targets at both ends of the offset range, wrap-around past the top of the address space, the overwriting of one return address by a nested linked jump, and opcode neighbours such as 19 that must not be taken for the jump.

// File: rtl/ubr_pkg.sv
package ubr_pkg;

    localparam int INSN_W = 32;
    localparam int OPCD_W = 6;
    localparam int OFS_W  = 24;
    localparam int DISP_W = OFS_W + 2;
    localparam logic [OPCD_W-1:0] OPCD_JUMP = 6'd18;

    typedef enum logic [1:0] {
        FLOW_SEQ = 2'd0,
        FLOW_REL = 2'd1,
        FLOW_ABS = 2'd2
    } flow_e;

    typedef struct packed {
        flow_e            flow;
        logic             link;
        logic [OFS_W-1:0] ofs;
    } jump_dec_t;

    function automatic logic [OPCD_W-1:0] opcd_of(input logic [INSN_W-1:0] w);
        return w[INSN_W-1 -: OPCD_W];
    endfunction

    function automatic logic [OFS_W-1:0] ofs_of(input logic [INSN_W-1:0] w);
        return w[OFS_W+1:2];
    endfunction

    function automatic logic [DISP_W-1:0] scale_ofs(input logic [OFS_W-1:0] o);
        return {o, 2'b00};
    endfunction

endpackage

// File: rtl/ubr_decode.sv
module ubr_decode
    import ubr_pkg::*;
(
    input  logic              valid,
    input  logic [INSN_W-1:0] insn,
    output jump_dec_t         dec,
    output logic              is_jump
);
    logic abs_bit;
    logic link_bit;

    always_comb begin
        abs_bit  = insn[1];
        link_bit = insn[0];
        is_jump  = valid && (opcd_of(insn) == OPCD_JUMP);
        dec.ofs  = ofs_of(insn);
        dec.link = is_jump && link_bit;
        if (!is_jump)
            dec.flow = FLOW_SEQ;
        else if (abs_bit)
            dec.flow = FLOW_ABS;
        else
            dec.flow = FLOW_REL;
    end
endmodule

// File: rtl/ubr_target.sv
module ubr_target
    import ubr_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] cur_pc,
    input  jump_dec_t         dec,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] seq_addr
);
    localparam int STEP = 4;

    logic [DISP_W-1:0] disp_raw;
    logic [ADDR_W-1:0] disp;

    assign disp_raw = scale_ofs(dec.ofs);

    generate
        if (ADDR_W > DISP_W) begin : g_extend
            assign disp = {{(ADDR_W-DISP_W){disp_raw[DISP_W-1]}}, disp_raw};
        end else begin : g_trunc
            assign disp = disp_raw[ADDR_W-1:0];
        end
    endgenerate

    assign seq_addr = cur_pc + ADDR_W'(STEP);

    always_comb begin
        case (dec.flow)
            FLOW_REL: target = cur_pc + disp;
            FLOW_ABS: target = disp;
            default:  target = seq_addr;
        endcase
    end
endmodule

// File: rtl/ubr_regs.sv
module ubr_regs
    import ubr_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reset_vec,
    input  logic              valid,
    input  logic              is_jump,
    input  jump_dec_t         dec,
    input  logic [ADDR_W-1:0] target,
    input  logic [ADDR_W-1:0] seq_addr,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] lr_q,
    output logic              taken_q,
    output logic              link_we_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q      <= reset_vec;
            lr_q      <= '0;
            taken_q   <= 1'b0;
            link_we_q <= 1'b0;
        end else begin
            taken_q   <= is_jump;
            link_we_q <= dec.link;
            if (valid)
                pc_q <= target;
            if (dec.link)
                lr_q <= seq_addr;
        end
    end
endmodule

// File: rtl/ubr_nextpc.sv
module ubr_nextpc
    import ubr_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reset_vec,
    input  logic              insn_valid,
    input  logic [INSN_W-1:0] insn,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] lr,
    output logic              taken,
    output logic              link_we
);
    jump_dec_t         dec;
    logic              is_jump;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] seq_addr;

    ubr_decode u_dec (
        .valid   (insn_valid),
        .insn    (insn),
        .dec     (dec),
        .is_jump (is_jump)
    );

    ubr_target #(.ADDR_W(ADDR_W)) u_tgt (
        .cur_pc   (pc),
        .dec      (dec),
        .target   (target),
        .seq_addr (seq_addr)
    );

    ubr_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reset_vec (reset_vec),
        .valid     (insn_valid),
        .is_jump   (is_jump),
        .dec       (dec),
        .target    (target),
        .seq_addr  (seq_addr),
        .pc_q      (pc),
        .lr_q      (lr),
        .taken_q   (taken),
        .link_we_q (link_we)
    );
endmodule

// File: rtl/ubr_nextpc_chk.sv
module ubr_nextpc_chk
    import ubr_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reset_vec,
    input logic              insn_valid,
    input logic [INSN_W-1:0] insn,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] lr,
    input logic              taken,
    input logic              link_we
);
    logic word_is_jump;
    assign word_is_jump = (insn[31:26] == OPCD_JUMP);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pc == $past(reset_vec)) && (lr == '0) && !taken && !link_we);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !insn_valid |=> $stable(pc) && $stable(lr) && !taken && !link_we);

    // R6
    seq_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && !word_is_jump) |=> (pc == $past(pc) + ADDR_W'(4)) && $stable(lr) && !taken);

    // R4
    abs_align_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && word_is_jump && insn[1]) |=> (pc[1:0] == 2'b00) && taken);

    // R8
    link_needs_jump_chk: assert property (@(posedge clk) disable iff (rst)
        link_we |-> taken);

    // R5
    link_value_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && word_is_jump && insn[0]) |=> link_we && (lr == $past(pc) + ADDR_W'(4)));
endmodule

bind ubr_nextpc ubr_nextpc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reset_vec  (reset_vec),
    .insn_valid (insn_valid),
    .insn       (insn),
    .pc         (pc),
    .lr         (lr),
    .taken      (taken),
    .link_we    (link_we)
);

// File: tb/sim_ubr_nextpc.sv
module sim_ubr_nextpc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] reset_vec = '0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] pc;
    logic [63:0] lr;
    logic        taken;
    logic        link_we;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ubr_nextpc u0 (
        .clk        (clk),
        .rst        (rst),
        .reset_vec  (reset_vec),
        .insn_valid (insn_valid),
        .insn       (insn),
        .pc         (pc),
        .lr         (lr),
        .taken      (taken),
        .link_we    (link_we)
    );

    typedef struct {
        logic [63:0] pc;
        logic [63:0] lr;
        logic        taken;
        logic        lwe;
        string       tag;
    } exp_t;

    exp_t sb[$];
    logic [63:0] m_pc = '0;
    logic [63:0] m_lr = '0;

    function automatic logic [31:0] jmp(input logic [23:0] ofs, input logic aa, input logic lk);
        return {6'd18, ofs, aa, lk};
    endfunction

    task automatic drive(input logic r, input logic [63:0] rv, input logic v,
                         input logic [31:0] w, input string tag);
        exp_t e;
        logic [63:0] disp;
        @(negedge clk);
        #1;
        rst = r; reset_vec = rv; insn_valid = v; insn = w;
        e.taken = 1'b0; e.lwe = 1'b0;
        if (r) begin
            m_pc = rv; m_lr = '0;
        end else if (v) begin
            if (w[31:26] == 6'd18) begin
                disp = {{38{w[25]}}, w[25:2], 2'b00};
                e.taken = 1'b1;
                if (w[0]) begin
                    m_lr = m_pc + 64'd4; e.lwe = 1'b1;
                end
                m_pc = w[1] ? disp : m_pc + disp;
            end else begin
                m_pc = m_pc + 64'd4;
            end
        end
        e.pc = m_pc; e.lr = m_lr; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic cmp(input string what, input logic [63:0] got, input logic [63:0] exp,
                       input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            cmp("pc", pc, e.pc, e.tag);
            cmp("lr", lr, e.lr, e.tag);
            cmp("taken", {63'd0, taken}, {63'd0, e.taken}, e.tag);
            cmp("link_we", {63'd0, link_we}, {63'd0, e.lwe}, e.tag);
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset
        drive(1'b1, 64'h0000_0000_0000_1000, 1'b0, '0, "R1");
        drive(1'b0, 64'hDEAD, 1'b0, '0, "R7_idle");
        // R6 non-jump words, incl. opcode neighbours 19 and 17
        drive(1'b0, '0, 1'b1, 32'h3860_0001, "R6");
        drive(1'b0, '0, 1'b1, {6'd19, 24'h000010, 2'b11}, "R2_r6_opcode19");
        drive(1'b0, '0, 1'b1, {6'd17, 24'h000010, 2'b01}, "R2_r6_opcode17");
        // R3 relative forward, no link
        drive(1'b0, '0, 1'b1, jmp(24'h000002, 1'b0, 1'b0), "R3");
        // R5 relative backward with link
        drive(1'b0, '0, 1'b1, jmp(24'hFFFFFC, 1'b0, 1'b1), "R5");
        // R7 jump word present but strobe low
        drive(1'b0, '0, 1'b0, jmp(24'h000100, 1'b1, 1'b1), "R7");
        // R4 absolute, no link
        drive(1'b0, '0, 1'b1, jmp(24'h000400, 1'b1, 1'b0), "R4");
        // R4 absolute negative with link
        drive(1'b0, '0, 1'b1, jmp(24'hFFFF00, 1'b1, 1'b1), "R4_r5_bla");
        // R11 nested linked relative jumps
        drive(1'b0, '0, 1'b1, jmp(24'h000010, 1'b0, 1'b1), "R11_first");
        drive(1'b0, '0, 1'b1, jmp(24'h000020, 1'b0, 1'b1), "R11");
        drive(1'b0, '0, 1'b1, 32'h6000_0000, "R8_pulse_drop");
        // R9 range extremes
        drive(1'b1, 64'h0000_0000_1000_0000, 1'b0, '0, "R1_again");
        drive(1'b0, '0, 1'b1, jmp(24'h7FFFFF, 1'b0, 1'b0), "R9_max");
        drive(1'b0, '0, 1'b1, jmp(24'h800000, 1'b0, 1'b0), "R9_min");
        drive(1'b0, '0, 1'b1, jmp(24'h800000, 1'b1, 1'b0), "R9_abs_min");
        // R10 wrap past top of address space
        drive(1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, '0, "R1_top");
        drive(1'b0, '0, 1'b1, jmp(24'h000008, 1'b0, 1'b1), "R10");
        drive(1'b0, '0, 1'b1, jmp(24'hFFFFF8, 1'b0, 1'b0), "R10_under");
        // back-to-back taken then idle: taken must drop
        drive(1'b0, '0, 1'b1, jmp(24'h000001, 1'b0, 1'b0), "R8");
        drive(1'b0, '0, 1'b0, '0, "R8_idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule